// File: doc/BRIEF.md
# Serial multichannel scan master

This block is the host side of a serial link to a 16-input, 12-bit converter that returns each result one frame after the request. On a start strobe it runs a scan over channels 0 to N-1: it drives chip select and the serial clock, shifts out one 16-bit command per frame, and shifts in the 16-bit reply at the same time. Each reply carries a 4-bit channel tag above the 12-bit result. Because the result arrives one frame late, the scan uses N+1 frames. The last frame only collects the result of the final channel.

Every accepted result goes out through a write port addressed by channel, so a result buffer can be filled directly from it. A reply whose tag does not match the channel requested in the previous frame is not written, and it sets a sticky error flag. After reset, the first scan is preceded by one all-ones frame that brings the converter to a known state. A one-cycle done pulse closes each scan.

Top module: `spi_scan_master`

## Requirements
- R1: After reset `cs_n` and `sclk` are 1 and `wr_en`, `done` and `err` are 0.
- R2: The first scan after reset starts with one extra frame whose command word is 16'hFFFF. Later scans have no such frame.
- R3: The command for channel k is, bit 15 down to 0: 1 (write enable), 0 (sequencer off), k in bits 13:10, 1 and 1 in bits 9:8 (full power), 0 in bit 7, 0 in bit 6 (output released between frames), the range bit in bit 5, the coding bit in bit 4, and zeros in bits 3:0.
- R4: Words go MSB first. `sclk` idles high and each bit is one low half followed by one high half. `mosi` changes only while `sclk` is high, and `miso` is sampled on each falling edge of `sclk`. The reply's bits 15:12 are the tag and bits 11:0 are the result.
- R5: A scan of N channels sends exactly N+1 command frames, for channels 0,1,…,N-1 and then a closing frame that requests channel 0.
- R6: The reply of scan frame f (f ≥ 1) is written to address f-1 with its low 12 bits. The reply of the first frame, and of the all-ones frame, is never written.
- R7: When a reply's tag differs from f-1, no write happens for that frame and `err` is set.
- R8: `err` stays set until the next accepted start strobe, which clears it.
- R9: `done` is a single-cycle pulse, given after the closing frame with `cs_n` high, exactly once per scan.
- R10: Between frames of a scan, `cs_n` stays high for at least GAP_HALVES·HALF_DIV clock cycles (four half periods by default).
- R11: A `num_ch` of 0 scans one channel, and a value above 16 scans 16.
- R12: A start strobe during a scan is ignored.
- R13: `cfg_range`, `cfg_coding` and `num_ch` are taken only in the cycle of the start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan (accepted when idle) |
| num_ch | input | 5 | Number of channels to scan |
| cfg_range | input | 1 | Range bit placed in each command |
| cfg_coding | input | 1 | Coding bit placed in each command |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Command data to converter |
| miso | input | 1 | Reply data from converter |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | 4 | Result channel index |
| wr_data | output | 12 | Result value |
| done | output | 1 | Scan finished pulse |
| err | output | 1 | Sticky tag-mismatch flag |

## Verification
A result write appears in the same clock cycle in which `cs_n` rises at the end of the frame that returned it. `done` follows GAP_HALVES·HALF_DIV cycles after `cs_n` rises on the closing frame. `err` clears one cycle after the start strobe is taken. The bench drives inputs and samples outputs on falling clock edges, so each of these results is read in the cycle it is due. The converter model captures each command when `cs_n` rises and applies the channel it requested to the reply it prepares for the next frame. Commands, writes, done pulses and chip-select gaps are all compared after the scan with values computed from the requirements.

// File: rtl/spi_scan_master.sv
module spi_scan_master #(
  parameter int HALF_DIV   = 2,
  parameter int GAP_HALVES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [4:0]  num_ch,
  input  logic        cfg_range,
  input  logic        cfg_coding,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        wr_en,
  output logic [3:0]  wr_addr,
  output logic [11:0] wr_data,
  output logic        done,
  output logic        err
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int GW = $clog2(GAP_HALVES + 1);

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gcnt;
  logic        ph, first_q, dummy_q, rng_r, cod_r;
  logic [3:0]  bcnt;
  logic [4:0]  fidx, num_r;
  logic [15:0] tx, rx;

  function automatic logic [15:0] cmd_word(input logic [3:0] ch, input logic r, input logic c);
    return {1'b1, 1'b0, ch, 2'b11, 1'b0, 1'b0, r, c, 4'b0000};
  endfunction

  wire       tick    = (cnt == CW'(HALF_DIV - 1));
  wire [4:0] num_eff = (num_ch == 5'd0) ? 5'd1 : (num_ch > 5'd16) ? 5'd16 : num_ch;
  wire [4:0] nf      = fidx + 5'd1;
  wire [3:0] nch     = (nf == num_r) ? 4'd0 : nf[3:0];
  wire [3:0] exp_tag = fidx[3:0] - 4'd1;
  wire       last_b  = tick && ph && (bcnt == 4'd15);

  assign mosi = tx[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; gcnt <= '0; ph <= 1'b0; bcnt <= '0;
      first_q <= 1'b1; dummy_q <= 1'b0; rng_r <= 1'b0; cod_r <= 1'b0;
      fidx <= '0; num_r <= 5'd1; tx <= '0; rx <= '0;
      cs_n <= 1'b1; sclk <= 1'b1;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      if (st != S_IDLE) cnt <= tick ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          err <= 1'b0; rng_r <= cfg_range; cod_r <= cfg_coding; num_r <= num_eff;
          fidx <= '0; dummy_q <= first_q; first_q <= 1'b0;
          tx <= first_q ? 16'hFFFF : cmd_word(4'd0, cfg_range, cfg_coding);
          cs_n <= 1'b0; cnt <= '0; ph <= 1'b0; bcnt <= '0; st <= S_FRAME;
        end
        S_FRAME: if (tick) begin
          if (!ph) begin
            sclk <= 1'b0; rx <= {rx[14:0], miso}; ph <= 1'b1;
          end else begin
            sclk <= 1'b1; ph <= 1'b0; tx <= {tx[14:0], 1'b0};
            if (bcnt == 4'd15) begin
              cs_n <= 1'b1; gcnt <= '0; st <= S_GAP;
              if (!dummy_q && fidx != 5'd0) begin
                if (rx[15:12] == exp_tag) begin
                  wr_en <= 1'b1; wr_addr <= exp_tag; wr_data <= rx[11:0];
                end else err <= 1'b1;
              end
            end else bcnt <= bcnt + 4'd1;
          end
        end
        S_GAP: if (tick) begin
          if (gcnt == GW'(GAP_HALVES - 1)) begin
            if (!dummy_q && fidx == num_r) begin
              done <= 1'b1; st <= S_IDLE;
            end else begin
              if (dummy_q) begin
                dummy_q <= 1'b0; tx <= cmd_word(4'd0, rng_r, cod_r);
              end else begin
                fidx <= nf; tx <= cmd_word(nch, rng_r, cod_r);
              end
              cs_n <= 1'b0; ph <= 1'b0; bcnt <= '0; st <= S_FRAME;
            end
          end else gcnt <= gcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> sclk);
  a_r4_mosi_stable_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $fell(sclk)) |-> $stable(mosi));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r9_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n) done |-> cs_n);
  a_r6_wr_addr_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} < num_r));
  a_r6_wr_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> $rose(cs_n));
  a_r7_no_write_on_error: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> !wr_en);
  a_r10_gap_min: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n);
endmodule

// File: tb/spi_scan_master_tb.sv
module spi_scan_master_tb;
  localparam int HALF = 2;
  localparam int GAPH = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cfg_range = 1'b0, cfg_coding = 1'b0, miso = 1'b0;
  logic [4:0] num_ch = 5'd0;
  logic cs_n, sclk, mosi, wr_en, done, err;
  logic [3:0] wr_addr;
  logic [11:0] wr_data;

  always #5 clk = ~clk;

  spi_scan_master #(.HALF_DIV(HALF), .GAP_HALVES(GAPH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_ch(num_ch), .cfg_range(cfg_range),
    .cfg_coding(cfg_coding), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .err(err));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_cmd(input int ch, input bit r, input bit c);
    logic [3:0] a = ch[3:0];
    return {1'b1, 1'b0, a, 2'b11, 1'b0, 1'b0, r, c, 4'b0000};
  endfunction

  function automatic logic [11:0] mk_data(input logic [3:0] ch, input logic [11:0] s);
    return 12'({8'd0, ch} * 12'd273) ^ s;
  endfunction

  // converter model
  logic [15:0] rep, cap, cmds[64];
  logic [3:0]  next_ch = 4'd0;
  logic [11:0] salt = 12'd0;
  int bitn = 0, frame_no = 0, corrupt_at = -1, ncmd = 0;

  always @(negedge cs_n) begin
    rep = {next_ch ^ ((frame_no == corrupt_at) ? 4'h1 : 4'h0), mk_data(next_ch, salt)};
    miso = rep[15];
    bitn = 0;
    cap = 16'd0;
  end
  always @(negedge sclk) if (!cs_n) begin
    cap = {cap[14:0], mosi};
    bitn++;
    miso = (bitn < 16) ? rep[15 - bitn] : 1'b0;
  end
  always @(posedge cs_n) if (bitn == 16) begin
    if (cap[15]) next_ch = cap[13:10];
    if (ncmd < 64) cmds[ncmd] = cap;
    ncmd++;
    frame_no++;
    bitn = 0;
  end

  // output monitor
  logic [12:0] got[16];
  int nwr = 0, ndone = 0, hi_cnt = 0, min_gap = 0;
  bit first_fall = 1'b1;
  logic cs_prev = 1'b1;
  always @(negedge clk) begin
    if (wr_en) begin got[wr_addr] = {1'b1, wr_data}; nwr++; end
    if (done) ndone++;
    if (cs_n) hi_cnt++;
    else if (cs_prev) begin
      if (!first_fall && hi_cnt < min_gap) min_gap = hi_cnt;
      first_fall = 1'b0;
      hi_cnt = 0;
    end
    cs_prev = cs_n;
  end

  bit first_scan = 1'b1;

  task automatic run_scan(input int n_in, input bit r, input bit c, input int corrupt, input bit poke);
    int neff, off, bad;
    neff = (n_in == 0) ? 1 : (n_in > 16) ? 16 : n_in;
    off = first_scan ? 1 : 0;
    salt = 12'($urandom);
    corrupt_at = (corrupt >= 0) ? corrupt + 1 + off : -1;
    frame_no = 0; ncmd = 0; nwr = 0; ndone = 0;
    min_gap = 1000000; first_fall = 1'b1;
    for (int i = 0; i < 16; i++) got[i] = 13'd0;
    @(negedge clk);
    start = 1'b1; num_ch = 5'(n_in); cfg_range = r; cfg_coding = c;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b0, "R8", "err after start", int'(err), 0);
    cfg_range = ~r; cfg_coding = ~c; num_ch = 5'($urandom_range(0, 31));
    if (poke) begin
      repeat (150) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (ndone == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ncmd == neff + 1 + off, poke ? "R12" : "R5", "frame count", ncmd, neff + 1 + off);
    if (first_scan) chk(cmds[0] == 16'hFFFF, "R2", "wake frame", int'(cmds[0]), 'hFFFF);
    else chk(cmds[0] == exp_cmd(0, r, c), "R2", "no wake frame", int'(cmds[0]), int'(exp_cmd(0, r, c)));
    bad = 0;
    for (int i = 0; i <= neff; i++)
      if (cmds[off + i] != exp_cmd((i < neff) ? i : 0, r, c)) bad++;
    chk(bad == 0, "R3", "command words MSB-first (R4)", bad, 0);
    chk(cmds[off + neff][5:4] == {r, c}, "R13", "cfg sampled at start", int'(cmds[off + neff][5:4]), int'({r, c}));
    bad = 0;
    for (int i = 0; i < neff; i++)
      if (i != corrupt && got[i] != {1'b1, mk_data(4'(i), salt)}) bad++;
    chk(bad == 0, (n_in == neff) ? "R6" : "R11", "stored results", bad, 0);
    if (corrupt >= 0) begin
      chk(got[corrupt][12] == 1'b0, "R7", "mismatch not written", int'(got[corrupt][12]), 0);
      chk(nwr == neff - 1, "R7", "write count", nwr, neff - 1);
      chk(err == 1'b1, "R7", "err set", int'(err), 1);
    end else begin
      chk(nwr == neff, "R6", "write count", nwr, neff);
      chk(err == 1'b0, "R7", "err clear", int'(err), 0);
    end
    chk(ndone == 1, "R9", "done pulses", ndone, 1);
    if (neff + off > 0) chk(min_gap >= GAPH * HALF, "R10", "cs gap", min_gap, GAPH * HALF);
    first_scan = 1'b0;
  endtask

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R1", "pins idle", int'({cs_n, sclk}), 3);
    chk(!wr_en && !done && !err, "R1", "outputs low", int'({wr_en, done, err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_scan(4, 1'b1, 1'b0, -1, 1'b0);
    run_scan(16, 1'b0, 1'b1, -1, 1'b0);
    run_scan(0, 1'b1, 1'b1, -1, 1'b0);
    run_scan(20, 1'b0, 1'b0, -1, 1'b0);
    run_scan(1, 1'b1, 1'b0, 0, 1'b0);
    run_scan(6, 1'b0, 1'b1, 5, 1'b0);
    repeat (40) @(negedge clk);
    chk(err == 1'b1, "R8", "err sticky while idle", int'(err), 1);
    run_scan(5, 1'b1, 1'b1, -1, 1'b1);
    for (int k = 0; k < 8; k++) begin
      n = $urandom_range(1, 16);
      run_scan(n, 1'($urandom), 1'($urandom), ($urandom_range(0, 2) == 0) ? $urandom_range(0, n - 1) : -1, 1'b0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule